// File: doc/BRIEF.md
# Branch Resolution and Cycle Budget Unit

This unit sits beside the instruction sequencer of a small 8-bit processor core. When an instruction starts, it takes the instruction kind, a 3-bit branch condition code, the four arithmetic status flags, the current program counter, a precomputed branch target and a page-crossing hint from operand address generation. For a conditional relative branch it decides whether the branch is taken and chooses the next program counter. For any instruction it charges the number of clock cycles the instruction occupies.

The charged count is loaded into a down-counter. The `busy` output stays high for exactly that many cycles, so the sequencer holds off the next instruction until `busy` falls. Branch cost depends on whether the branch is taken and on whether the target lies in a different 256-byte page from the program counter. Cost for other instructions is a base cycle count supplied by the decoder, plus one when an indexed operand crosses a page. The target adder and instruction fetch live elsewhere.

Top module: `brn_resolver`

## Requirements
- R1: `cond_code[2:1]` selects the tested flag: 00 carry, 01 zero, 10 negative, 11 overflow. `cond_code[0]` is the sense: 1 means taken when the flag is 1, and 0 means taken when the flag is 0. The three unselected flags have no effect.
- R2: An accepted branch whose condition fails costs 2 cycles and sets `taken` to 0 and `next_pc` to `cur_pc`.
- R3: An accepted branch whose condition holds, with target and `cur_pc` in the same page, costs 3 cycles and sets `taken` to 1 and `next_pc` to `tgt_pc`.
- R4: A taken branch whose target differs from `cur_pc` in bits [15:8] costs 5 cycles. The comparison uses `cur_pc` as presented with the start, before the target is loaded.
- R5: `page_cross` has no effect on the cost of a branch.
- R6: An accepted non-branch costs `base_cycles` plus 1 when `page_cross` is 1, saturating at 15. It sets `taken` to 0 and `next_pc` to `cur_pc`. The condition code and flags are ignored.
- R7: After the clock edge that accepts a start, `busy` is high for exactly as many cycles as the cost, then falls. A cost of 0 leaves `busy` low.
- R8: A `start` seen while `busy` is high is ignored: `next_pc`, `taken` and the remaining busy time are unchanged.
- R9: Synchronous reset drives `busy` and `taken` to 0 and `next_pc` to 0. `next_pc` and `taken` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted only when not busy) |
| is_branch | input | 1 | 1 for a conditional relative branch |
| cond_code | input | 3 | Flag select [2:1] and sense [0] |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| cur_pc | input | 16 | Program counter before the instruction resolves |
| tgt_pc | input | 16 | Computed branch target |
| page_cross | input | 1 | Indexed operand address crossed a page |
| base_cycles | input | 4 | Base cost of a non-branch instruction |
| next_pc | output | 16 | Resolved program counter |
| taken | output | 1 | Last accepted branch was taken |
| busy | output | 1 | Cycle budget still counting down |

## Verification
A wrong condition decode or a stale program counter appears on `taken` and `next_pc` one cycle after the accepting edge, so it is caught on the first sample after each start. A wrong cost or a counter that fails to reload shows up only as a `busy` window of the wrong length. The length is therefore counted cycle by cycle for every vector, including the zero-cost and saturated cases. Acceptance during `busy` would corrupt the outputs of the running instruction and stretch the window; both effects are visible by the time the original window closes.

// File: rtl/brn_pkg.sv
package brn_pkg;

    typedef enum logic [1:0] {
        SEL_CARRY = 2'b00,
        SEL_ZERO  = 2'b01,
        SEL_NEG   = 2'b10,
        SEL_OVF   = 2'b11
    } flag_sel_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        flag_sel_e sel;
        logic      sense;
    } cond_t;

    localparam int unsigned COST_NOT_TAKEN = 2;
    localparam int unsigned COST_TAKEN     = 3;
    localparam int unsigned COST_FAR       = 5;

    function automatic logic pick_flag(input flags_t f, input flag_sel_e s);
        logic r;
        case (s)
            SEL_CARRY: r = f.c;
            SEL_ZERO:  r = f.z;
            SEL_NEG:   r = f.n;
            default:   r = f.v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
    import brn_pkg::*;
(
    input  cond_t  cond,
    input  flags_t flags,
    output logic   met
);
    always_comb begin
        met = (pick_flag(flags, cond.sel) == cond.sense);
    end
endmodule

// File: rtl/brn_cost_calc.sv
module brn_cost_calc
    import brn_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int PAGE_BITS = 8,
    parameter int CNT_W     = 4
) (
    input  logic             is_branch,
    input  logic             met,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  target,
    input  logic             page_cross,
    input  logic [CNT_W-1:0] base,
    output logic [CNT_W-1:0] cost,
    output logic             take,
    output logic [PC_W-1:0]  pc_sel
);
    localparam logic [CNT_W:0] MAX_COST = {1'b0, {CNT_W{1'b1}}};

    logic           far;
    logic [CNT_W:0] raw;

    always_comb begin
        far  = (pc[PC_W-1:PAGE_BITS] != target[PC_W-1:PAGE_BITS]);
        take = is_branch && met;
        if (is_branch) begin
            if (!met)
                raw = (CNT_W+1)'(COST_NOT_TAKEN);
            else if (far)
                raw = (CNT_W+1)'(COST_FAR);
            else
                raw = (CNT_W+1)'(COST_TAKEN);
        end else begin
            raw = {1'b0, base} + {{CNT_W{1'b0}}, page_cross};
        end
        cost   = (raw > MAX_COST) ? MAX_COST[CNT_W-1:0] : raw[CNT_W-1:0];
        pc_sel = take ? target : pc;
    end
endmodule

// File: rtl/brn_cycle_ctr.sv
module brn_cycle_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cost,
    output logic             accept,
    output logic             busy
);
    logic [CNT_W-1:0] remain;

    always_comb begin
        busy   = (remain != '0);
        accept = start && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (accept)
            remain <= cost;
        else if (busy)
            remain <= remain - 1'b1;
    end
endmodule

// File: rtl/brn_resolver.sv
module brn_resolver
    import brn_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int PAGE_BITS = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_branch,
    input  logic [2:0]       cond_code,
    input  logic             flag_c,
    input  logic             flag_z,
    input  logic             flag_n,
    input  logic             flag_v,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  tgt_pc,
    input  logic             page_cross,
    input  logic [CNT_W-1:0] base_cycles,
    output logic [PC_W-1:0]  next_pc,
    output logic             taken,
    output logic             busy
);
    cond_t            cond;
    flags_t           flags;
    logic             met;
    logic             take_w;
    logic [PC_W-1:0]  pc_w;
    logic [CNT_W-1:0] cost_w;
    logic             accept;

    always_comb begin
        cond.sel   = flag_sel_e'(cond_code[2:1]);
        cond.sense = cond_code[0];
        flags.c    = flag_c;
        flags.z    = flag_z;
        flags.n    = flag_n;
        flags.v    = flag_v;
    end

    brn_cond_eval u_cond (
        .cond  (cond),
        .flags (flags),
        .met   (met)
    );

    brn_cost_calc #(
        .PC_W      (PC_W),
        .PAGE_BITS (PAGE_BITS),
        .CNT_W     (CNT_W)
    ) u_cost (
        .is_branch  (is_branch),
        .met        (met),
        .pc         (cur_pc),
        .target     (tgt_pc),
        .page_cross (page_cross),
        .base       (base_cycles),
        .cost       (cost_w),
        .take       (take_w),
        .pc_sel     (pc_w)
    );

    brn_cycle_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cost   (cost_w),
        .accept (accept),
        .busy   (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc <= '0;
            taken   <= 1'b0;
        end else if (accept) begin
            next_pc <= pc_w;
            taken   <= take_w;
        end
    end
endmodule

// File: rtl/brn_resolver_chk.sv
module brn_resolver_chk #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             is_branch,
    input logic [2:0]       cond_code,
    input logic             flag_c,
    input logic             flag_z,
    input logic             flag_n,
    input logic             flag_v,
    input logic [PC_W-1:0]  cur_pc,
    input logic [PC_W-1:0]  tgt_pc,
    input logic [PC_W-1:0]  next_pc,
    input logic             taken,
    input logic             busy
);
    logic tested;
    logic cond_true;
    logic go;

    always_comb begin
        unique case (cond_code[2:1])
            2'b00:   tested = flag_c;
            2'b01:   tested = flag_z;
            2'b10:   tested = flag_n;
            default: tested = flag_v;
        endcase
        cond_true = cond_code[0] ? tested : !tested;
        go        = start && !busy;
    end

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!busy && !taken && next_pc == '0));

    // R8
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(next_pc) && $stable(taken)));

    // R2
    not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (go && is_branch && !cond_true) |=> (!taken && next_pc == $past(cur_pc)));

    // R3
    taken_target_chk: assert property (@(posedge clk) disable iff (rst)
        (go && is_branch && cond_true) |=> (taken && next_pc == $past(tgt_pc)));

    // R6
    non_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !is_branch) |=> (!taken && next_pc == $past(cur_pc)));

    // R7
    branch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (go && is_branch) |=> busy);

    // R7
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);
endmodule

bind brn_resolver brn_resolver_chk #(
    .PC_W  (PC_W),
    .CNT_W (CNT_W)
) u_brn_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_branch (is_branch),
    .cond_code (cond_code),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .flag_v    (flag_v),
    .cur_pc    (cur_pc),
    .tgt_pc    (tgt_pc),
    .next_pc   (next_pc),
    .taken     (taken),
    .busy      (busy)
);

// File: tb/tb_brn_resolver.sv
module tb_brn_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_branch = 1'b0;
    logic [2:0]  cond_code = '0;
    logic        flag_c = 1'b0, flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
    logic [15:0] cur_pc = '0, tgt_pc = '0;
    logic        page_cross = 1'b0;
    logic [3:0]  base_cycles = '0;
    logic [15:0] next_pc;
    logic        taken, busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    brn_resolver dut (
        .clk(clk), .rst(rst), .start(start), .is_branch(is_branch),
        .cond_code(cond_code), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v), .cur_pc(cur_pc), .tgt_pc(tgt_pc),
        .page_cross(page_cross), .base_cycles(base_cycles),
        .next_pc(next_pc), .taken(taken), .busy(busy)
    );

    typedef struct packed {
        logic        br;
        logic [2:0]  cc;
        logic [3:0]  fl;    // {c, z, n, v}
        logic [15:0] pc;
        logic [15:0] tg;
        logic        px;
        logic [3:0]  base;
        logic        etk;
        logic [15:0] epc;
        logic [4:0]  ecyc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'd0, 4'b0111, 16'h1234, 16'h1250, 1'b0, 4'd0,  1'b1, 16'h1250, 5'd3},  // R1 R3 carry clear
        '{1'b1, 3'd1, 4'b0000, 16'h1234, 16'h1250, 1'b0, 4'd0,  1'b0, 16'h1234, 5'd2},  // R2 carry set fails
        '{1'b1, 3'd3, 4'b0100, 16'h12F0, 16'h1310, 1'b0, 4'd0,  1'b1, 16'h1310, 5'd5},  // R4 zero set, far
        '{1'b1, 3'd2, 4'b0100, 16'h12F0, 16'h1310, 1'b0, 4'd0,  1'b0, 16'h12F0, 5'd2},  // R2 zero clear fails
        '{1'b1, 3'd4, 4'b1101, 16'h8000, 16'h7FF0, 1'b0, 4'd0,  1'b1, 16'h7FF0, 5'd5},  // R4 backward far
        '{1'b1, 3'd5, 4'b0010, 16'h4410, 16'h4480, 1'b0, 4'd0,  1'b1, 16'h4480, 5'd3},  // R3 negative set
        '{1'b1, 3'd6, 4'b0001, 16'h4410, 16'h4480, 1'b0, 4'd0,  1'b0, 16'h4410, 5'd2},  // R1 overflow clear fails
        '{1'b1, 3'd7, 4'b0001, 16'hFFF0, 16'h0005, 1'b0, 4'd0,  1'b1, 16'h0005, 5'd5},  // R4 wrap far
        '{1'b1, 3'd0, 4'b1000, 16'h0200, 16'h0210, 1'b1, 4'd9,  1'b0, 16'h0200, 5'd2},  // R5 cross ignored
        '{1'b1, 3'd0, 4'b0000, 16'h0200, 16'h0210, 1'b1, 4'd9,  1'b1, 16'h0210, 5'd3},  // R5 taken, cross ignored
        '{1'b0, 3'd0, 4'b0000, 16'h2000, 16'h3000, 1'b1, 4'd4,  1'b0, 16'h2000, 5'd5},  // R6 base+cross
        '{1'b0, 3'd7, 4'b0001, 16'h2100, 16'h3000, 1'b0, 4'd3,  1'b0, 16'h2100, 5'd3},  // R6 base only
        '{1'b0, 3'd0, 4'b0000, 16'h2200, 16'h3000, 1'b0, 4'd0,  1'b0, 16'h2200, 5'd0},  // R7 zero cost
        '{1'b0, 3'd0, 4'b0000, 16'h2300, 16'h3000, 1'b1, 4'd15, 1'b0, 16'h2300, 5'd15}  // R6 saturate
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        is_branch   = v.br;
        cond_code   = v.cc;
        {flag_c, flag_z, flag_n, flag_v} = v.fl;
        cur_pc      = v.pc;
        tgt_pc      = v.tg;
        page_cross  = v.px;
        base_cycles = v.base;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        int n;
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(taken == v.etk, {req, " taken"}, taken, v.etk);
        check(next_pc == v.epc, {req, " next_pc"}, next_pc, v.epc);
        n = 0;
        while (busy && n < 40) begin
            n++;
            @(negedge clk);
        end
        check(n == int'(v.ecyc), {req, " R7 busy cycles"}, n, v.ecyc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(!busy, "R9 busy", busy, 0);
        check(!taken, "R9 taken", taken, 0);
        check(next_pc == 16'h0, "R9 next_pc", next_pc, 0);

        for (int i = 0; i < NV; i++)
            run_vec(TBL[i], $sformatf("vec%0d", i));

        // R8: start during busy is ignored
        @(negedge clk);
        drive(TBL[2]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        @(negedge clk);
        n++;
        drive(TBL[1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n++;
        check(next_pc == 16'h1310, "R8 next_pc kept", next_pc, 16'h1310);
        check(taken == 1'b1, "R8 taken kept", taken, 1);
        while (busy && n < 40) begin
            @(negedge clk);
            if (busy) n++;
        end
        check(n == 5, "R8 busy window unchanged", n, 5);
        check(next_pc == 16'h1310, "R9 hold after window", next_pc, 16'h1310);

        // R9 reset during busy
        @(negedge clk);
        drive(TBL[4]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy, "R9 mid-busy reset busy", busy, 0);
        check(!taken, "R9 mid-busy reset taken", taken, 0);
        check(next_pc == 16'h0, "R9 mid-busy reset next_pc", next_pc, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule